// File: doc/BRIEF.md
# DRAM Init and Refresh Scheduler

This block brings a 256-row EDO DRAM out of power-up and keeps its rows refreshed for as long as the chip runs. When reset is released it first holds the memory idle for a programmable start-up delay. It then issues a fixed number of warm-up refresh cycles. After the last warm-up cycle it raises a ready flag, and the access controller may start host traffic only once that flag is high.

In normal running, an interval timer produces one refresh tick every period/256 clock cycles. The interval is the standard one or the longer low-power one, chosen by a strap input. Each tick asks the access controller for the bus through a request/grant handshake. When the grant is given, the block itself drives the row and column strobes through a CAS-before-RAS sequence. The address pins are not involved, because the memory supplies the row from its own counter. The access controller must float the data pins while the busy output is high.

If grants are withheld, ticks are kept as a backlog up to a small limit. Those refreshes are issued back to back once the bus is granted again. A tick that would exceed the limit sets a sticky error flag, because the refresh budget is then broken.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, both strobes are high and ref_req, ref_busy, init_done and backlog_err are low.
- R2: No refresh request and no strobe activity occur during the first STARTUP_CYC cycles after reset is released, even when ref_gnt is held high.
- R3: Exactly INIT_CNT refresh cycles are issued before init_done rises. init_done stays low throughout all of them, and once it is high it stays high until reset.
- R4: In every refresh, CAS falls while RAS is high and RAS has been high for at least PRE_CYC cycles. CAS then stays low for exactly CSR_CYC cycles before RAS falls.
- R5: RAS stays low for exactly RAS_CYC cycles. CAS and RAS return high in the same cycle.
- R6: With lp_mode low and the grant given at once, successive refresh starts after initialisation are exactly INT_STD cycles apart.
- R7: With lp_mode high and the grant given at once, successive refresh starts after initialisation are exactly INT_LP cycles apart.
- R8: ref_req stays high until it is granted. ref_gnt while ref_req is low starts nothing. ref_busy is high whenever either strobe is low, and ref_req is low while ref_busy is high.
- R9: Ticks that arrive while the grant is withheld are kept, up to MAX_PEND of them. Once the grant returns, that many refreshes are issued back to back.
- R10: A tick that arrives with MAX_PEND refreshes already waiting, and none granted in that cycle, sets backlog_err. The flag stays set until reset and is never set when the backlog stays within the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lp_mode | input | 1 | Strap: 1 selects the long low-power refresh interval |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Refresh bus request |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| ref_busy | output | 1 | Refresh sequence in progress; the controller keeps DQ floating |
| init_done | output | 1 | Initialisation complete; host access allowed |
| backlog_err | output | 1 | Sticky: refresh backlog exceeded its limit |

## Verification
The bench measures the spacing of refresh starts in both interval modes. A pacer that restarted its count on each grant, or that was off by one cycle, would drift from the exact interval. It withholds the grant over zero, one, two and three ticks and counts the back-to-back burst that follows. A backlog that did not saturate would release three refreshes instead of two. A backlog that was lost would release none, and an overflow check placed at the wrong depth would flag the error too early or not at all. It also counts the warm-up refreshes seen before the ready flag rises, and checks the strobe overlap in every cycle. The second check would catch CAS released before RAS, or RAS dropped first, which would turn the cycle into a row-only refresh.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_INIT,
        PH_RUN
    } phase_e;

    typedef enum logic [2:0] {
        SB_IDLE,
        SB_PRE,
        SB_CAS,
        SB_BOTH,
        SB_RECOV
    } strobe_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_pins_t;

    // bits needed to hold values 0 .. n-1
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_startup.sv
module dref_startup
    import dref_pkg::*;
#(
    parameter int unsigned STARTUP_CYC = 10000,
    parameter int unsigned INIT_CNT    = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  logic   busy,
    output phase_e phase,
    output logic   init_want
);
    localparam int unsigned SW = cnt_w(STARTUP_CYC);
    localparam int unsigned IW = cnt_w(INIT_CNT + 1);

    logic [SW-1:0] wait_cnt;
    logic [IW-1:0] init_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_WAIT;
            wait_cnt  <= '0;
            init_left <= IW'(INIT_CNT);
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (wait_cnt == SW'(STARTUP_CYC - 1)) phase <= PH_INIT;
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                PH_INIT: begin
                    if (take) init_left <= init_left - 1'b1;
                    if (init_left == '0 && !busy) phase <= PH_RUN;
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    assign init_want = (phase == PH_INIT) && (init_left != '0);

endmodule

// File: rtl/dref_pacer.sv
module dref_pacer
    import dref_pkg::*;
#(
    parameter int unsigned INT_STD  = 1562,
    parameter int unsigned INT_LP   = 12500,
    parameter int unsigned MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic lp_mode,
    input  logic take,
    output logic pend_nz,
    output logic overrun_err
);
    localparam int unsigned TW = cnt_w(max2(INT_STD, INT_LP));
    localparam int unsigned PW = cnt_w(MAX_PEND + 1);

    logic [TW-1:0] tcnt;
    logic [TW-1:0] lim_m1;
    logic [PW-1:0] pend;
    logic          tick;
    logic          full;

    assign lim_m1 = lp_mode ? TW'(INT_LP - 1) : TW'(INT_STD - 1);
    assign tick   = run && (tcnt >= lim_m1);
    assign full   = (pend == PW'(MAX_PEND));

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt        <= '0;
            pend        <= '0;
            overrun_err <= 1'b0;
        end else begin
            if (!run || tick) tcnt <= '0;
            else tcnt <= tcnt + 1'b1;

            case ({tick, take})
                2'b10:   if (!full) pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase

            if (tick && full && !take) overrun_err <= 1'b1;
        end
    end

    assign pend_nz = (pend != '0);

endmodule

// File: rtl/dref_strobe.sv
module dref_strobe
    import dref_pkg::*;
#(
    parameter int unsigned PRE_CYC = 1,
    parameter int unsigned CSR_CYC = 1,
    parameter int unsigned RAS_CYC = 5,
    parameter int unsigned RP_CYC  = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic         busy,
    output strobe_pins_t pins
);
    localparam int unsigned MAXL = max2(max2(PRE_CYC, CSR_CYC), max2(RAS_CYC, RP_CYC));
    localparam int unsigned CW   = cnt_w(MAXL);

    strobe_e       st;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SB_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SB_IDLE: if (start) begin
                    st  <= SB_PRE;
                    cnt <= CW'(PRE_CYC - 1);
                end
                SB_PRE: if (last) begin
                    st  <= SB_CAS;
                    cnt <= CW'(CSR_CYC - 1);
                end else cnt <= cnt - 1'b1;
                SB_CAS: if (last) begin
                    st  <= SB_BOTH;
                    cnt <= CW'(RAS_CYC - 1);
                end else cnt <= cnt - 1'b1;
                SB_BOTH: if (last) begin
                    st  <= SB_RECOV;
                    cnt <= CW'(RP_CYC - 1);
                end else cnt <= cnt - 1'b1;
                SB_RECOV: if (last) st <= SB_IDLE;
                          else cnt <= cnt - 1'b1;
                default: st <= SB_IDLE;
            endcase
        end
    end

    assign busy       = (st != SB_IDLE);
    assign pins.cas_n = !((st == SB_CAS) || (st == SB_BOTH));
    assign pins.ras_n = (st != SB_BOTH);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dref_pkg::*;
#(
    parameter int unsigned STARTUP_CYC = 10000,
    parameter int unsigned INIT_CNT    = 8,
    parameter int unsigned INT_STD     = 1562,
    parameter int unsigned INT_LP      = 12500,
    parameter int unsigned MAX_PEND    = 4,
    parameter int unsigned PRE_CYC     = 1,
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned RAS_CYC     = 5,
    parameter int unsigned RP_CYC      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_mode,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic ref_busy,
    output logic init_done,
    output logic backlog_err
);
    phase_e       phase;
    logic         init_want;
    logic         run;
    logic         pend_nz;
    logic         start;
    logic         busy;
    strobe_pins_t pins;

    dref_startup #(
        .STARTUP_CYC(STARTUP_CYC),
        .INIT_CNT   (INIT_CNT)
    ) i_startup (
        .clk      (clk),
        .rst      (rst),
        .take     (start),
        .busy     (busy),
        .phase    (phase),
        .init_want(init_want)
    );

    assign run = (phase == PH_RUN);

    dref_pacer #(
        .INT_STD (INT_STD),
        .INT_LP  (INT_LP),
        .MAX_PEND(MAX_PEND)
    ) i_pacer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .lp_mode    (lp_mode),
        .take       (start && run),
        .pend_nz    (pend_nz),
        .overrun_err(backlog_err)
    );

    dref_strobe #(
        .PRE_CYC(PRE_CYC),
        .CSR_CYC(CSR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC)
    ) i_strobe (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .busy (busy),
        .pins (pins)
    );

    assign ref_req   = !busy && (init_want || (run && pend_nz));
    assign start     = ref_req && ref_gnt;
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;
    assign ref_busy  = busy;
    assign init_done = run;

endmodule

// File: rtl/dref_checker.sv
module dref_checker (
    input logic clk,
    input logic rst,
    input logic ref_gnt,
    input logic ref_req,
    input logic ras_n,
    input logic cas_n,
    input logic ref_busy,
    input logic init_done,
    input logic backlog_err
);
    AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n); // R4

    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> !$past(cas_n)); // R4

    AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> $rose(ras_n)); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_gnt) |=> ref_req); // R8

    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> ref_busy); // R8

    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> !ref_req); // R8

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        backlog_err |=> backlog_err); // R10

    AST_ERR_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        backlog_err |-> init_done); // R10

endmodule

bind dram_refresh_sched dref_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .ref_busy   (ref_busy),
    .init_done  (init_done),
    .backlog_err(backlog_err)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int STARTUP    = 30;
    localparam int INIT       = 4;
    localparam int ISTD       = 48;
    localparam int ILP        = 96;
    localparam int MAXP       = 2;
    localparam int PRE        = 2;
    localparam int CSR        = 1;
    localparam int RAS        = 3;
    localparam int RP         = 2;
    localparam int WDOG       = 100000;

    typedef struct packed {
        logic       lp;
        logic [3:0] k;
        logic [3:0] burst;
        logic       err;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 4'd0, 1'b0},
        '{1'b0, 4'd1, 4'd1, 1'b0},
        '{1'b0, 4'd2, 4'd2, 1'b0},
        '{1'b0, 4'd3, 4'd2, 1'b1},
        '{1'b1, 4'd1, 4'd1, 1'b0},
        '{1'b1, 4'd3, 4'd2, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp_mode = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ras_n, cas_n, ref_busy, init_done, backlog_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_sched #(
        .STARTUP_CYC(STARTUP), .INIT_CNT(INIT), .INT_STD(ISTD), .INT_LP(ILP),
        .MAX_PEND(MAXP), .PRE_CYC(PRE), .CSR_CYC(CSR), .RAS_CYC(RAS), .RP_CYC(RP)
    ) i_dram_refresh_sched (
        .clk(clk), .rst(rst), .lp_mode(lp_mode), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .ref_busy(ref_busy),
        .init_done(init_done), .backlog_err(backlog_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // strobe monitor, sampled on the falling edge
    logic p_cas = 1'b1;
    logic p_ras = 1'b1;
    int cas_low_run = 0;
    int ras_low_run = 0;
    int ras_high_run = 1000;
    int n_fall = 0;
    int last_fall = 0;
    int prev_fall = 0;
    int first_fall = -1;

    always @(negedge clk) begin
        if (rst) begin
            p_cas = 1'b1; p_ras = 1'b1;
            cas_low_run = 0; ras_low_run = 0; ras_high_run = 1000;
            n_fall = 0; first_fall = -1;
        end else begin
            if (p_cas && !cas_n) begin
                n_fall++;
                prev_fall = last_fall;
                last_fall = cyc;
                if (first_fall < 0) first_fall = cyc;
                check(ras_n == 1'b1 && ras_high_run >= PRE, "R4 ras high before cas", ras_high_run, PRE);
                check(ref_busy == 1'b1, "R8 busy during refresh", int'(ref_busy), 1);
                if (n_fall <= INIT)
                    check(init_done == 1'b0, "R3 ready low during init", int'(init_done), 0);
            end
            if (p_ras && !ras_n)
                check(cas_low_run == CSR, "R4 cas lead", cas_low_run, CSR);
            if (!p_ras && ras_n) begin
                check(ras_low_run == RAS, "R5 ras width", ras_low_run, RAS);
                check(cas_n == 1'b1, "R5 cas rises with ras", int'(cas_n), 1);
            end
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            p_cas = cas_n;
            p_ras = ras_n;
        end
    end

    task automatic tick1;
        @(posedge clk);
        #1;
    endtask

    task automatic reset_and_init(input logic lp);
        int rel;
        rst = 1'b1;
        ref_gnt = 1'b1;
        lp_mode = lp;
        repeat (3) tick1();
        // R1: reset state
        check(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
        check(!ref_req && !ref_busy, "R1 req/busy low in reset", {ref_req, ref_busy}, 0);
        check(!init_done, "R1 ready low in reset", int'(init_done), 0);
        check(!backlog_err, "R10 error cleared by reset", int'(backlog_err), 0);
        rst = 1'b0;
        rel = cyc;
        tick1();
        check(ras_n && cas_n && !ref_req && !init_done && !backlog_err,
              "R1 first cycle after reset", {ras_n, cas_n, ref_req, init_done, backlog_err}, 24);
        repeat (STARTUP / 2) tick1();
        // R8: grant held while nothing is requested starts nothing
        check(cas_n && ras_n && !ref_busy && !ref_req, "R8 grant without request",
              {cas_n, ras_n, ref_busy, ref_req}, 12);
        while (!init_done) tick1();
        check(first_fall - rel >= STARTUP, "R2 start-up quiet time", first_fall - rel, STARTUP);
        check(first_fall - rel <= STARTUP + PRE + 4, "R2 first refresh soon after delay",
              first_fall - rel, STARTUP + PRE + 4);
        check(n_fall == INIT, "R3 init refresh count", n_fall, INIT);
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin
            int ival;
            int f0;
            int f1;
            vec_t cur;
            cur = VECS[v];
            ival = cur.lp ? ILP : ISTD;
            reset_and_init(cur.lp);
            f0 = n_fall;
            while (n_fall < f0 + 2) tick1();
            check(last_fall - prev_fall == ival, cur.lp ? "R7 low-power spacing" : "R6 standard spacing",
                  last_fall - prev_fall, ival);
            // withhold the grant over k ticks
            ref_gnt = 1'b0;
            repeat (int'(cur.k) * ival + ival / 2) tick1();
            check(ref_req == (cur.k != 0), "R8 request held while not granted",
                  int'(ref_req), int'(cur.k != 0));
            ref_gnt = 1'b1;
            f1 = n_fall;
            repeat (ival / 2 - 4) tick1();
            check(n_fall - f1 == int'(cur.burst), "R9 backlog burst", n_fall - f1, int'(cur.burst));
            check(backlog_err == cur.err, "R10 backlog error", int'(backlog_err), int'(cur.err));
            if (cur.err) begin
                repeat (ival) tick1();
                check(backlog_err == 1'b1, "R10 error sticky", int'(backlog_err), 1);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule